// File: doc/BRIEF.md
# Binary32 Compare to Condition Flags

This block compares two IEEE 754 binary32 words, a first operand and a second operand. It returns the relation between them as a four-bit condition code and raises an invalid-operation flag. The logic is purely combinational, so the code for a pair of words is valid in the same cycle those words are presented. The flags can then be latched by whatever status logic sits downstream.

Two controls choose the compare variant. One control makes quiet NaNs raise invalid, as signalling NaNs always do. The other control compares the first operand against positive zero and ignores the second word. The ordering of numbers comes from integer comparison of the raw words, combined with their sign bits. Zeros of opposite sign compare equal.

Top module: `fcmp_flags`

## Requirements
- R1: `nzcv_o` carries N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. Equal operands give 4'b0110 (Z and C). It only ever shows one of the codes 4'b0110, 4'b1000, 4'b0010 or 4'b0011.
- R2: A word whose bits [30:23] are all ones and whose bits [22:0] are nonzero is a NaN. If either compared operand is a NaN, the code is unordered, 4'b0011 (C and V). Infinities are not NaNs and are ordered normally.
- R3: A NaN with bit 22 clear is signalling and always sets `invalid_o`. A NaN with bit 22 set is quiet and sets `invalid_o` only while `quiet_sig_i` is 1.
- R4: Two zeros compare equal whatever their signs.
- R5: If the sign bits (bit 31) differ and the operands are not both zero, the negative operand is the smaller. First-operand-smaller gives 4'b1000 (N), and first-operand-larger gives 4'b0010 (C).
- R6: If the sign bits match, the unsigned comparison of the raw words decides the order. The result is inverted when both operands are negative.
- R7: While `zero_cmp_i` is 1, positive zero replaces `b_i`. The value on `b_i`, including a NaN, has no effect on either output.
- R8: With no NaN among the compared operands, `invalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand, binary32 |
| b_i | input | 32 | Second operand, binary32 |
| quiet_sig_i | input | 1 | Quiet NaNs also raise invalid |
| zero_cmp_i | input | 1 | Compare `a_i` against +0 instead of `b_i` |
| nzcv_o | output | 4 | Condition code {N,Z,C,V} |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
Both outputs are due zero cycles after a change on any input, because no register lies on any path. The bench drives each operand pair just after a rising clock edge and samples the two outputs at the following falling edge. By then the combinational result has settled, and nothing new has been driven yet. The same timing is used for the reset-state check, for the table walk and for the directed NaN and zero-substitution cases.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2
  } cmp_rel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              is_nan_o,
  output logic              is_snan_o,
  output logic              is_zero_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f     = word_i[WORD_W-2 -: EXP_W];
  assign man_f     = word_i[MAN_W-1:0];
  assign is_nan_o  = (&exp_f) && (|man_f);
  // top mantissa bit clear marks a signalling NaN
  assign is_snan_o = is_nan_o && !man_f[MAN_W-1];
  assign is_zero_o = ~|word_i[WORD_W-2:0];
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] d_i,
  input  logic [WORD_W-1:0] m_i,
  input  logic              d_zero_i,
  input  logic              m_zero_i,
  output cmp_rel_e          rel_o
);
  logic d_neg, m_neg, raw_lt;

  assign d_neg  = d_i[WORD_W-1];
  assign m_neg  = m_i[WORD_W-1];
  assign raw_lt = d_i < m_i;

  always_comb begin
    if (d_i == m_i || (d_zero_i && m_zero_i)) begin
      rel_o = REL_EQ;
    end else if (d_neg != m_neg) begin
      rel_o = d_neg ? REL_LT : REL_GT;
    end else begin
      // magnitude order reverses for two negatives
      rel_o = (raw_lt ^ d_neg) ? REL_LT : REL_GT;
    end
  end
endmodule

// File: rtl/fcmp_encode.sv
module fcmp_encode
  import fcmp_pkg::*;
(
  input  logic     unordered_i,
  input  cmp_rel_e rel_i,
  output nzcv_t    nzcv_o
);
  always_comb begin
    nzcv_o = '0;
    if (unordered_i) begin
      nzcv_o.c = 1'b1;
      nzcv_o.v = 1'b1;
    end else begin
      unique case (rel_i)
        REL_EQ:  begin nzcv_o.z = 1'b1; nzcv_o.c = 1'b1; end
        REL_LT:  nzcv_o.n = 1'b1;
        REL_GT:  nzcv_o.c = 1'b1;
        default: nzcv_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W,
  localparam int N_OPND = 2
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              quiet_sig_i,
  input  logic              zero_cmp_i,
  output logic [3:0]        nzcv_o,
  output logic              invalid_o
);
  logic [WORD_W-1:0] opnd [N_OPND];
  logic [N_OPND-1:0] nan_v, snan_v, zero_v, raise_v;
  cmp_rel_e          rel;
  nzcv_t             code;

  assign opnd[0] = a_i;
  assign opnd[1] = zero_cmp_i ? '0 : b_i;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
    fcmp_classify #(
      .EXP_W(EXP_W),
      .MAN_W(MAN_W)
    ) u_cls (
      .word_i   (opnd[gi]),
      .is_nan_o (nan_v[gi]),
      .is_snan_o(snan_v[gi]),
      .is_zero_o(zero_v[gi])
    );
    assign raise_v[gi] = nan_v[gi] && (snan_v[gi] || quiet_sig_i);
  end

  fcmp_order #(
    .WORD_W(WORD_W)
  ) u_order (
    .d_i     (opnd[0]),
    .m_i     (opnd[1]),
    .d_zero_i(zero_v[0]),
    .m_zero_i(zero_v[1]),
    .rel_o   (rel)
  );

  fcmp_encode u_enc (
    .unordered_i(|nan_v),
    .rel_i      (rel),
    .nzcv_o     (code)
  );

  assign nzcv_o    = code;
  assign invalid_o = |raise_v;
endmodule

// File: rtl/fcmp_flags_chk.sv
module fcmp_flags_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic              quiet_sig_i,
  input logic              zero_cmp_i,
  input logic [3:0]        nzcv_o,
  input logic              invalid_o
);
  logic [WORD_W-1:0] b_eff;
  logic a_nan, b_nan, a_snan, both_zero, sign_diff;

  always_comb begin
    b_eff     = zero_cmp_i ? '0 : b_i;
    a_nan     = (&a_i[WORD_W-2 -: EXP_W]) && (|a_i[MAN_W-1:0]);
    b_nan     = (&b_eff[WORD_W-2 -: EXP_W]) && (|b_eff[MAN_W-1:0]);
    a_snan    = a_nan && !a_i[MAN_W-1];
    both_zero = ~|(a_i[WORD_W-2:0] | b_eff[WORD_W-2:0]);
    sign_diff = a_i[WORD_W-1] ^ b_eff[WORD_W-1];
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, quiet_sig_i, zero_cmp_i, nzcv_o, invalid_o})) begin
      p_code_legal_r1: assert (nzcv_o == 4'b0110 || nzcv_o == 4'b1000 ||
                               nzcv_o == 4'b0010 || nzcv_o == 4'b0011)
        else $error("illegal code %b", nzcv_o);
      p_nan_unordered_r2: assert (!(a_nan || b_nan) || nzcv_o == 4'b0011)
        else $error("NaN not unordered");
      p_snan_invalid_r3: assert (!a_snan || invalid_o)
        else $error("signalling NaN without invalid");
      p_zero_equal_r4: assert (!(both_zero && !a_nan && !b_nan) || nzcv_o == 4'b0110)
        else $error("zeros not equal");
      p_sign_order_r5: assert (!(sign_diff && !both_zero && !a_nan && !b_nan) ||
                               nzcv_o == (a_i[WORD_W-1] ? 4'b1000 : 4'b0010))
        else $error("sign order wrong");
      p_quiet_invalid_r8: assert ((a_nan || b_nan) || !invalid_o)
        else $error("invalid without NaN");
    end
  end
endmodule

bind fcmp_flags fcmp_flags_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (.*);

// File: tb/fcmp_flags_tb.sv
module fcmp_flags_tb;
  localparam int NV = 22;
  localparam logic [3:0] EQ = 4'b0110, LT = 4'b1000, GT = 4'b0010, UN = 4'b0011;

  // {a, b, quiet_sig, zero_cmp, nzcv, invalid}
  localparam logic [70:0] VECS [NV] = '{
    {32'h3F800000, 32'h3F800000, 1'b0, 1'b0, EQ, 1'b0},
    {32'h3F800000, 32'h40000000, 1'b0, 1'b0, LT, 1'b0},
    {32'h40000000, 32'h3F800000, 1'b0, 1'b0, GT, 1'b0},
    {32'hBF800000, 32'h3F800000, 1'b0, 1'b0, LT, 1'b0},
    {32'h3F800000, 32'hBF800000, 1'b0, 1'b0, GT, 1'b0},
    {32'hBF800000, 32'hC0000000, 1'b0, 1'b0, GT, 1'b0},
    {32'hC0000000, 32'hBF800000, 1'b0, 1'b0, LT, 1'b0},
    {32'h80000000, 32'h00000000, 1'b0, 1'b0, EQ, 1'b0},
    {32'h00000000, 32'h80000000, 1'b0, 1'b0, EQ, 1'b0},
    {32'h7FC00000, 32'h3F800000, 1'b0, 1'b0, UN, 1'b0},
    {32'h7FC00000, 32'h3F800000, 1'b1, 1'b0, UN, 1'b1},
    {32'h7F800001, 32'h3F800000, 1'b0, 1'b0, UN, 1'b1},
    {32'h3F800000, 32'h7FA00000, 1'b0, 1'b0, UN, 1'b1},
    {32'h7F800000, 32'h7F7FFFFF, 1'b0, 1'b0, GT, 1'b0},
    {32'hFF800000, 32'hFF800000, 1'b0, 1'b0, EQ, 1'b0},
    {32'h00000001, 32'h00000000, 1'b0, 1'b0, GT, 1'b0},
    {32'hBF800000, 32'h7FC00000, 1'b1, 1'b1, LT, 1'b0},
    {32'h80000000, 32'h3F800000, 1'b0, 1'b1, EQ, 1'b0},
    {32'h7FC00000, 32'h7F800001, 1'b1, 1'b1, UN, 1'b1},
    {32'h00000001, 32'hFF800000, 1'b0, 1'b1, GT, 1'b0},
    {32'h80000001, 32'h00000000, 1'b0, 1'b0, LT, 1'b0},
    {32'hFFC00000, 32'hFFC00000, 1'b0, 1'b0, UN, 1'b0}
  };
  localparam string TAGS [NV] = '{
    "R1", "R6", "R6", "R5", "R5", "R6", "R6", "R4", "R4", "R2", "R3",
    "R3", "R3", "R2", "R1", "R8", "R7", "R7", "R7", "R7", "R5", "R2"
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic        qs, zc;
  logic [3:0]  nzcv;
  logic        inv;
  int          n_checks = 0;
  int          n_fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fcmp_flags u_dut (
    .a_i        (a),
    .b_i        (b),
    .quiet_sig_i(qs),
    .zero_cmp_i (zc),
    .nzcv_o     (nzcv),
    .invalid_o  (inv)
  );

  task automatic apply(input logic [31:0] av, input logic [31:0] bv,
                       input logic q, input logic z);
    @(posedge clk);
    #1;
    a = av; b = bv; qs = q; zc = z;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] en, input logic ei);
    n_checks++;
    if (nzcv !== en || inv !== ei) begin
      n_fails++;
      $display("FAIL %s: a=%h b=%h nzcv=%b inv=%b expected nzcv=%b inv=%b",
               req, a, b, nzcv, inv, en, ei);
    end
  endtask

  initial begin
    a = '0; b = '0; qs = 1'b0; zc = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset state", EQ, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][70:39], VECS[i][38:7], VECS[i][6], VECS[i][5]);
      check(TAGS[i], VECS[i][4:1], VECS[i][0]);
    end

    // R3: quiet NaN versus signalling NaN, control clear
    apply(32'h7FC00000, 32'h7F800001, 1'b0, 1'b0);
    check("R3", UN, 1'b1);
    // R8: quiet NaN control set with no NaN present
    apply(32'h40000000, 32'h40000000, 1'b1, 1'b0);
    check("R8", EQ, 1'b0);
    // R7: signalling NaN on b ignored under zero compare
    apply(32'hC0000000, 32'h7F800001, 1'b0, 1'b1);
    check("R7", LT, 1'b0);
    // R6: neighbouring negatives
    apply(32'hBF800001, 32'hBF800000, 1'b0, 1'b0);
    check("R6", LT, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule